// File: doc/BRIEF.md
# SPI Bus Master with Register Interface

This block is a serial peripheral interface master that a processor drives through a 32-bit Wishbone slave port. Software loads up to 128 bits of transmit data into four data words and sets the character length, clock edges, bit order and slave-select options in a control word. It then sets the start bit. The block shifts the character out on MOSI and shifts the reply from MISO into the same register. When the transfer ends, the received bits can be read back from the same four word addresses.

The serial clock rate comes from a divider register, and eight active-low select lines come from a select register. The select lines can either follow that register at all times or be asserted only while a transfer runs. An optional interrupt flags the end of each transfer.

The Wishbone port is the only data interface. It carries its own back-pressure: a request is the pair CYC and STB, and the block answers with a one-cycle ACK in the clock after it samples the request. The requester must hold CYC, STB, WE, address and write data steady until it sees ACK, and must drop STB in the cycle after ACK unless it issues a new request. There is no other stall, and ERR is never asserted.

Top module: `spi_bus_master`

## Requirements
- R1: A request (CYC and STB high while ACK is low) is answered by ACK high for exactly one cycle, in the clock after the request is sampled. Write data and address are taken in that same cycle.
- R2: Byte address 0x10 is the control word (bits [13:0]), 0x14 the divider and 0x18 the select register. Each reads back the value last written, with control bit 8 showing the live busy state. Addresses 0x00, 0x04, 0x08 and 0x0C are data words 0 to 3, covering shift-register bits [31:0], [63:32], [95:64] and [127:96].
- R3: Control bits [6:0] give the character length N in bits. A value of 0 gives N = 128.
- R4: Writing control with bit 8 set starts a transfer. Bit 8 reads 1 until the transfer ends and then reads 0 without any further write.
- R5: SCLK is low when idle. A transfer makes N rising and N falling SCLK edges, and every SCLK half period after the first edge lasts divider+1 system clocks.
- R6: Control bit 10 set means MOSI changes on falling SCLK edges, with the first bit presented before the first rising edge. When bit 10 is clear, MOSI changes on rising edges. The slave receives the N transmit bits in order.
- R7: Control bit 9 set means MISO is sampled on falling SCLK edges. When bit 9 is clear, MISO is sampled on rising edges.
- R8: With control bit 11 clear, bit N-1 is sent first and the first received bit lands in bit N-1. With bit 11 set, bit 0 goes first and the first received bit lands in bit 0. Received data is right-aligned, and shift-register bits at N and above keep their transmit value.
- R9: With control bit 12 set, the interrupt output rises when a transfer ends and falls at the next accepted Wishbone request. With bit 12 clear, it stays low.
- R10: The select outputs are the bitwise inverse of the select register. With control bit 13 set, all select outputs stay high except while busy.
- R11: While busy, writes to any address are acknowledged and ignored. Reads are still served.
- R12: After reset all registers and data words read 0, the select outputs are all high, and SCLK, MOSI and the interrupt are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc | input | 1 | Bus cycle active |
| wb_stb | input | 1 | Request strobe |
| wb_we | input | 1 | Write when high, read when low |
| wb_adr | input | 5 | Byte address |
| wb_dat_w | input | 32 | Write data |
| wb_dat_r | output | 32 | Read data, valid with ACK |
| wb_ack | output | 1 | One-cycle acknowledge |
| wb_err | output | 1 | Error response, always low |
| irq | output | 1 | End-of-transfer interrupt |
| ss_n | output | SS_W | Active-low slave selects |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Transfers run against a bench slave that captures MOSI on the edge opposite to the one the master drives it on. The slave also drives MISO from its own random bit pattern, changing it away from the edge the master samples on.

Directed transfers cover all four pairings of the drive and sample edges, both bit orders, and the 1-bit and 128-bit lengths. Together they separate an edge-select fault from an ordering fault, and they expose a wrong length encoding through the edge count and the untouched upper bits.

Random transfers vary length, divider, edges, interrupt use and automatic select. They catch position arithmetic that only goes wrong at odd lengths. A long transfer with register writes issued mid-flight shows that writes made while busy leave data, control, divider and select unchanged.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;
  localparam int MAX_BITS = 128;
  localparam int LEN_W    = $clog2(MAX_BITS);
  localparam int N_WORDS  = MAX_BITS / 32;

  typedef enum logic [2:0] {
    SEL_D0   = 3'd0,
    SEL_D1   = 3'd1,
    SEL_D2   = 3'd2,
    SEL_D3   = 3'd3,
    SEL_CTRL = 3'd4,
    SEL_DIV  = 3'd5,
    SEL_SS   = 3'd6
  } reg_sel_e;

  // control word, bit 13 down to bit 0
  typedef struct packed {
    logic             auto_ss;
    logic             irq_en;
    logic             lsb_first;
    logic             tx_fall;
    logic             rx_fall;
    logic             busy;
    logic             rsv;
    logic [LEN_W-1:0] len;
  } ctrl_t;
endpackage

// File: rtl/spi_bm_sclk.sv
module spi_bm_sclk #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             rise_p,
  output logic             fall_p
);
  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick   = run && (cnt == '0);
  assign rise_p = tick && !sclk;
  assign fall_p = tick && sclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (start) begin
      cnt  <= div;
      sclk <= 1'b0;
    end else if (run) begin
      if (tick) begin
        cnt  <= div;
        sclk <= ~sclk;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else begin
      sclk <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_bm_shift.sv
module spi_bm_shift
  import spi_bm_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [LEN_W-1:0]    len,
  input  logic                lsb_first,
  input  logic                tx_fall,
  input  logic                rx_fall,
  input  logic                rise_p,
  input  logic                fall_p,
  input  logic                miso,
  input  logic [N_WORDS-1:0]  wr_en,
  input  logic [31:0]         wr_data,
  output logic [MAX_BITS-1:0] sr,
  output logic                mosi,
  output logic                active,
  output logic                done
);
  localparam int CNT_W = LEN_W + 1;

  logic [CNT_W-1:0] nbits, tx_k, rx_k, f_k;
  logic             tx_ev, rx_ev;

  assign nbits = (len == '0) ? CNT_W'(MAX_BITS) : {1'b0, len};
  assign tx_ev = tx_fall ? fall_p : rise_p;
  assign rx_ev = rx_fall ? fall_p : rise_p;
  assign done  = active && fall_p && (f_k == nbits - 1'b1);

  // shift-register position of the k-th bit on the wire
  function automatic logic [LEN_W-1:0] bit_pos(input logic [CNT_W-1:0] k,
                                               input logic [CNT_W-1:0] n,
                                               input logic lsb);
    logic [CNT_W-1:0] p;
    p = lsb ? k : (n - 1'b1 - k);
    return p[LEN_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      mosi   <= 1'b0;
      active <= 1'b0;
      tx_k   <= '0;
      rx_k   <= '0;
      f_k    <= '0;
    end else begin
      if (start) begin
        active <= 1'b1;
        rx_k   <= '0;
        f_k    <= '0;
        if (tx_fall) begin
          mosi <= sr[bit_pos('0, nbits, lsb_first)];
          tx_k <= CNT_W'(1);
        end else begin
          tx_k <= '0;
        end
      end else if (active) begin
        if (tx_ev && (tx_k < nbits)) begin
          mosi <= sr[bit_pos(tx_k, nbits, lsb_first)];
          tx_k <= tx_k + 1'b1;
        end
        if (rx_ev && (rx_k < nbits)) begin
          sr[bit_pos(rx_k, nbits, lsb_first)] <= miso;
          rx_k <= rx_k + 1'b1;
        end
        if (fall_p) begin
          f_k <= f_k + 1'b1;
          if (f_k == nbits - 1'b1) active <= 1'b0;
        end
      end
      for (int w = 0; w < N_WORDS; w++) begin
        if (wr_en[w]) sr[w*32 +: 32] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/spi_bus_master.sv
module spi_bus_master
  import spi_bm_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int SS_W  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wb_cyc,
  input  logic            wb_stb,
  input  logic            wb_we,
  input  logic [4:0]      wb_adr,
  input  logic [31:0]     wb_dat_w,
  output logic [31:0]     wb_dat_r,
  output logic            wb_ack,
  output logic            wb_err,
  output logic            irq,
  output logic [SS_W-1:0] ss_n,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso
);
  ctrl_t                ctrl;
  logic [DIV_W-1:0]     div_q;
  logic [SS_W-1:0]      ssel;
  logic                 req, wr_ok, busy, auto_ss, start_q;
  logic                 xfer_done, active, rise_p, fall_p;
  logic [MAX_BITS-1:0]  sr;
  logic [N_WORDS-1:0]   word_we;
  reg_sel_e             sel;
  logic                 unused_bits;

  assign req         = wb_cyc && wb_stb && !wb_ack;
  assign sel         = reg_sel_e'(wb_adr[4:2]);
  assign busy        = ctrl.busy;
  assign auto_ss     = ctrl.auto_ss;
  assign wr_ok       = req && wb_we && !busy;
  assign wb_err      = 1'b0;
  assign ss_n        = ~((auto_ss && !busy) ? '0 : ssel);
  assign unused_bits = ^{wb_adr[1:0], wb_dat_w};

  generate
    for (genvar w = 0; w < N_WORDS; w++) begin : g_word_we
      assign word_we[w] = wr_ok && (wb_adr[4:2] == 3'(w));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      div_q    <= '0;
      ssel     <= '0;
      start_q  <= 1'b0;
      wb_ack   <= 1'b0;
      wb_dat_r <= '0;
      irq      <= 1'b0;
    end else begin
      wb_ack  <= req;
      start_q <= 1'b0;
      if (req) irq <= 1'b0;
      if (xfer_done) begin
        ctrl.busy <= 1'b0;
        if (ctrl.irq_en) irq <= 1'b1;
      end
      if (wr_ok) begin
        case (sel)
          SEL_CTRL: begin
            ctrl    <= ctrl_t'(wb_dat_w[13:0]);
            start_q <= wb_dat_w[8];
          end
          SEL_DIV: div_q <= wb_dat_w[DIV_W-1:0];
          SEL_SS:  ssel  <= wb_dat_w[SS_W-1:0];
          default: ;
        endcase
      end
      if (req) begin
        case (sel)
          SEL_D0, SEL_D1, SEL_D2, SEL_D3: wb_dat_r <= sr[{wb_adr[3:2], 5'b0} +: 32];
          SEL_CTRL: wb_dat_r <= {18'b0, ctrl};
          SEL_DIV:  wb_dat_r <= 32'(div_q);
          SEL_SS:   wb_dat_r <= 32'(ssel);
          default:  wb_dat_r <= '0;
        endcase
      end
    end
  end

  spi_bm_sclk #(.DIV_W(DIV_W)) u_sclk (
    .clk    (clk),
    .rst    (rst),
    .start  (start_q),
    .run    (active),
    .div    (div_q),
    .sclk   (sclk),
    .rise_p (rise_p),
    .fall_p (fall_p)
  );

  spi_bm_shift u_shift (
    .clk       (clk),
    .rst       (rst),
    .start     (start_q),
    .len       (ctrl.len),
    .lsb_first (ctrl.lsb_first),
    .tx_fall   (ctrl.tx_fall),
    .rx_fall   (ctrl.rx_fall),
    .rise_p    (rise_p),
    .fall_p    (fall_p),
    .miso      (miso),
    .wr_en     (word_we),
    .wr_data   (wb_dat_w),
    .sr        (sr),
    .mosi      (mosi),
    .active    (active),
    .done      (xfer_done)
  );
endmodule

// File: rtl/spi_bus_master_chk.sv
module spi_bus_master_chk #(
  parameter int SS_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            wb_cyc,
  input logic            wb_stb,
  input logic            wb_ack,
  input logic            irq,
  input logic            busy,
  input logic            xfer_done,
  input logic            sclk,
  input logic            auto_ss,
  input logic [SS_W-1:0] ss_n
);
  a_r1_ack_follows_req: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && wb_stb && !wb_ack) |=> wb_ack);

  a_r1_ack_one_cycle: assert property (@(posedge clk) disable iff (rst)
    wb_ack |=> !wb_ack);

  a_r4_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && !xfer_done) |=> busy);

  a_r5_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk);

  a_r9_irq_from_end: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(xfer_done));

  a_r9_irq_cleared: assert property (@(posedge clk) disable iff (rst)
    (irq && wb_cyc && wb_stb && !wb_ack && !xfer_done) |=> !irq);

  a_r10_auto_idle_high: assert property (@(posedge clk) disable iff (rst)
    (auto_ss && !busy) |-> (ss_n == '1));

  a_r11_ss_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(ss_n));
endmodule

bind spi_bus_master spi_bus_master_chk #(.SS_W(SS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wb_cyc    (wb_cyc),
  .wb_stb    (wb_stb),
  .wb_ack    (wb_ack),
  .irq       (irq),
  .busy      (busy),
  .xfer_done (xfer_done),
  .sclk      (sclk),
  .auto_ss   (auto_ss),
  .ss_n      (ss_n)
);

// File: tb/spi_bus_master_bench.sv
module spi_bus_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_CTRL = 5'h10, A_DIV = 5'h14, A_SS = 5'h18;

  logic        clk = 1'b0, rst = 1'b1;
  logic        wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
  logic [4:0]  wb_adr = '0;
  logic [31:0] wb_dat_w = '0, wb_dat_r;
  logic        wb_ack, wb_err, irq, sclk, mosi, miso = 1'b0;
  logic [7:0]  ss_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_bus_master u_spi_bus_master (
    .clk(clk), .rst(rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_adr(wb_adr), .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r), .wb_ack(wb_ack),
    .wb_err(wb_err), .irq(irq), .ss_n(ss_n), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  int checks = 0, fails = 0, ack_bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wb_do(input bit we, input logic [4:0] a, input logic [31:0] d, output logic [31:0] q);
    int lat = 0;
    @(negedge clk);
    wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = we; wb_adr = a; wb_dat_w = d;
    do begin @(negedge clk); lat++; end while (!wb_ack && lat < 20);
    if (lat != 1) ack_bad++;
    q = wb_dat_r;
    wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
  endtask

  task automatic wb_wr(input logic [4:0] a, input logic [31:0] d);
    logic [31:0] q;
    wb_do(1'b1, a, d, q);
  endtask

  task automatic wb_rd(input logic [4:0] a, output logic [31:0] q);
    wb_do(1'b0, a, 32'h0, q);
  endtask

  // bench slave model, evaluated away from the active edge
  logic [127:0] s_bits = '0, cap_v = '0;
  int s_idx = 0, rise_n = 0, cap_n = 0, edge_n = 0, since = 0, half_bad = 0, exp_half = 1;
  bit m_tx_fall = 0, m_rx_fall = 0;
  logic prev_sclk = 1'b0;

  always @(negedge clk) begin
    since++;
    if (sclk !== prev_sclk) begin
      if (edge_n > 0 && since != exp_half) half_bad++;
      edge_n++;
      since = 0;
      if (sclk) begin
        rise_n++;
        if (m_tx_fall && cap_n < 128) begin cap_v[cap_n] = mosi; cap_n++; end
        if (m_rx_fall && rise_n > 1) s_idx++;
      end else begin
        if (!m_tx_fall && cap_n < 128) begin cap_v[cap_n] = mosi; cap_n++; end
        if (!m_rx_fall) s_idx++;
      end
    end
    prev_sclk = sclk;
    miso = (s_idx < 128) ? s_bits[s_idx] : 1'b0;
  end

  function automatic int bpos(int k, int n, bit lsb);
    return lsb ? k : n - 1 - k;
  endfunction

  task automatic do_xfer(input int len, input bit txf, input bit rxf, input bit lsb,
                         input bit ie, input bit ass, input int dv, input logic [7:0] ssv,
                         input logic [127:0] tx, input logic [127:0] sv, input bit poke);
    int n, t;
    logic [127:0] exp_sr, exp_cap, mask, got;
    logic [31:0] cw, q;
    n = (len == 0) ? 128 : len;
    wb_wr(A_DIV, 32'(dv));
    wb_wr(A_SS, 32'(ssv));
    for (int w = 0; w < 4; w++) wb_wr(5'(w*4), tx[w*32 +: 32]);
    cw = {18'b0, ass, ie, lsb, txf, rxf, 1'b0, 1'b0, 7'(len)};
    wb_wr(A_CTRL, cw);
    s_bits = sv; s_idx = 0; rise_n = 0; cap_n = 0; cap_v = '0; edge_n = 0;
    half_bad = 0; exp_half = dv + 1; m_tx_fall = txf; m_rx_fall = rxf;
    exp_sr = tx; exp_cap = '0; mask = '0;
    for (int k = 0; k < n; k++) begin
      exp_sr[bpos(k, n, lsb)] = sv[k];
      exp_cap[k] = tx[bpos(k, n, lsb)];
      mask[k] = 1'b1;
    end
    wb_wr(A_CTRL, cw | 32'h100);
    check(ss_n === ~ssv, "R10 select during transfer", 128'(ss_n), 128'(~ssv));
    if (poke) begin
      wb_wr(5'h00, ~tx[31:0]);
      wb_wr(A_CTRL, 32'h0);
      wb_wr(A_SS, 32'(~ssv));
      wb_wr(A_DIV, 32'(dv + 5));
    end
    if (ie) begin
      t = 0;
      while (irq !== 1'b1 && t < 5000) begin @(negedge clk); t++; end
      check(irq === 1'b1, "R9 interrupt at end", 128'(irq), 128'(1));
      wb_rd(A_CTRL, q);
      check(irq === 1'b0, "R9 interrupt cleared by access", 128'(irq), 128'(0));
    end else begin
      t = 0;
      q = 32'h100;
      while (q[8] && t < 5000) begin wb_rd(A_CTRL, q); t++; end
      check(irq === 1'b0, "R9 interrupt disabled stays low", 128'(irq), 128'(0));
    end
    check(q == cw, "R4 R2 R11 control readback after transfer", 128'(q), 128'(cw));
    check(ss_n === (ass ? 8'hFF : ~ssv), "R10 select after transfer", 128'(ss_n), 128'(ass ? 8'hFF : ~ssv));
    for (int w = 0; w < 4; w++) begin wb_rd(5'(w*4), q); got[w*32 +: 32] = q; end
    check(got == exp_sr, "R7 R8 R3 R11 received data", got, exp_sr);
    check(cap_n == n && (cap_v & mask) == exp_cap, "R6 R3 bits seen by slave", cap_v & mask, exp_cap);
    check(half_bad == 0 && edge_n == 2*n, "R5 SCLK edges and half period",
          128'(edge_n) | (128'(half_bad) << 64), 128'(2*n));
    wb_rd(A_DIV, q);
    check(q == 32'(dv), "R2 R11 divider readback", 128'(q), 128'(dv));
    wb_rd(A_SS, q);
    check(q == 32'(ssv), "R2 R11 select readback", 128'(q), 128'(ssv));
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    logic [31:0] q;
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ss_n === 8'hFF && sclk === 1'b0 && mosi === 1'b0 && irq === 1'b0 && wb_ack === 1'b0,
          "R12 outputs after reset", {ss_n, sclk, mosi, irq, wb_ack}, {8'hFF, 4'b0});
    wb_rd(A_CTRL, q); check(q == 0, "R12 control reset", 128'(q), 0);
    wb_rd(A_DIV, q);  check(q == 0, "R12 divider reset", 128'(q), 0);
    wb_rd(A_SS, q);   check(q == 0, "R12 select reset", 128'(q), 0);
    wb_rd(5'h0C, q);  check(q == 0, "R12 data reset", 128'(q), 0);

    do_xfer(8,  0, 1, 0, 0, 0, 0, 8'h01, 128'h5a, 128'ha5, 0);
    do_xfer(8,  1, 0, 0, 0, 0, 1, 8'h80, 128'ha5, 128'h3c, 0);
    do_xfer(16, 1, 1, 1, 0, 0, 2, 8'h02, rnd128(), rnd128(), 0);
    do_xfer(64, 0, 1, 1, 0, 0, 0, 8'h10, rnd128(), rnd128(), 0);
    do_xfer(0,  1, 0, 0, 0, 0, 3, 8'h3c, rnd128(), rnd128(), 1);
    do_xfer(32, 0, 0, 0, 1, 1, 1, 8'h41, rnd128(), rnd128(), 0);
    do_xfer(1,  0, 1, 0, 1, 1, 0, 8'h01, rnd128(), rnd128(), 0);
    for (int i = 0; i < 10; i++)
      do_xfer($urandom_range(127, 0), 1'($urandom()), 1'($urandom()), 1'($urandom()),
              1'($urandom()), 1'($urandom()), $urandom_range(3, 0), 8'($urandom()),
              rnd128(), rnd128(), 0);

    check(ack_bad == 0, "R1 ack one cycle after request", 128'(ack_bad), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R4 transfer never completed actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule